// File: doc/BRIEF.md
# Local Countdown Interrupt Timer

This block is a programmable countdown timer that raises an interrupt request when its count runs out. A 32-bit vector entry register controls it. The entry holds the interrupt vector, the delivery mode, a level/edge trigger flag, a mask flag and a periodic/one-shot selector. Software writes an initial count, and the current count then steps down by one on every cycle in which the external tick enable is high.

When the count reaches zero, the block issues a one-cycle request pulse that carries the vector, delivery mode and trigger flag from the entry. The pulse is not issued if the entry is masked. In periodic mode the count reloads from the initial count and keeps running. In one-shot mode it stays at zero until software writes a new initial count. Clock division, bus decoding and message delivery sit outside this block, so the tick enable arrives already divided.

Top module: `lvec_timer`

## Requirements
- R1: After asynchronous reset, the entry reads 0x0001_0000 (mask set), the initial count reads 0, the current count reads 0, and irq_o is low.
- R2: Address 0 is the entry. Bits 7:0 are the vector, 10:8 the delivery mode, 13 the polarity, 15 the trigger flag (1 = level), 16 the mask and 17 the periodic select, and all of these are writable. Bit 12 (delivery status), bit 14 (remote-request flag), bit 11 and bits 31:18 ignore writes and read 0, so writing 0xFFFF_FFFF reads back 0x0003_A7FF.
- R3: A write to address 1 sets both the initial count and the current count to the written value. A written value of zero leaves the timer stopped, with no request.
- R4: While the current count is nonzero, it drops by one on each clock edge at which tick_i is high and no initial-count write occurs. When tick_i is low, the count holds.
- R5: irq_o is high for exactly the one cycle that follows the clock edge at which a tick moves the count from 1 to expiry, and it is low otherwise.
- R6: During the request pulse, irq_vector_o, irq_mode_o and irq_level_o equal the entry's bits 7:0, 10:8 and 15 as they were at the expiring edge.
- R7: When entry bit 16 is set, expiry produces no pulse, although counting and reloading continue.
- R8: When entry bit 17 is set, expiry reloads the current count from the initial count, so an initial count N gives one expiry every N ticks.
- R9: When entry bit 17 is clear, the count stays at 0 after expiry and further ticks raise no request until the initial count is written again.
- R10: Address 2 reads the current count, and writes to it are ignored. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address (0 entry, 1 initial count, 2 current count) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tick_i | input | 1 | Count enable from the external divider |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| irq_vector_o | output | 8 | Vector carried by the request |
| irq_mode_o | output | 3 | Delivery mode carried by the request |
| irq_level_o | output | 1 | Trigger flag carried by the request (1 = level) |

## Verification
Some rules are checked on every cycle:
- a pulse only follows a tick edge;
- a masked entry never produces a pulse;
- the request fields match the entry as it was at the expiring edge;
- each tick steps the count down by one;
- the count holds while there is no tick;
- a zero count stays at zero;
- periodic expiry reloads the count from the initial count.

Other behaviour only the bench's scenarios can show:
- the number of expiries over a long run in each mode;
- the exact cycle of the pulse after a known number of ticks;
- the register readback masking;
- a restart after rewriting the initial count;
- the state after a mid-run reset.

// File: rtl/lvec_timer_pkg.sv
package lvec_timer_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_ENTRY = 2'd0;
  localparam logic [ADDR_W-1:0] A_INIT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CUR   = 2'd2;

  // writable entry bits: vec, mode, polarity, trigger, mask, periodic
  localparam logic [DATA_W-1:0] ENTRY_WMASK = 32'h0003_A7FF;
  localparam logic [DATA_W-1:0] ENTRY_RST   = 32'h0001_0000;

  typedef struct packed {
    logic [13:0] rsvd;
    logic        periodic;
    logic        mask;
    logic        level;
    logic        rirr;
    logic        pol;
    logic        busy;
    logic        rsv11;
    logic [2:0]  mode;
    logic [7:0]  vec;
  } entry_t;

  typedef struct packed {
    logic [7:0] vec;
    logic [2:0] mode;
    logic       level;
  } req_t;
endpackage

// File: rtl/lvec_timer_regs.sv
module lvec_timer_regs
  import lvec_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cur_i,
  output entry_t            entry_o,
  output logic [CNT_W-1:0]  init_o,
  output logic              load_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] entry_q;
  logic [CNT_W-1:0]  init_q;
  logic              entry_we;

  assign entry_we = wr_en_i && (addr_i == A_ENTRY);
  assign load_o   = wr_en_i && (addr_i == A_INIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= ENTRY_RST;
    end else if (entry_we) begin
      entry_q <= wdata_i & ENTRY_WMASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
    end else if (load_o) begin
      init_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign entry_o = entry_t'(entry_q);
  assign init_o  = init_q;

  always_comb begin
    unique case (addr_i)
      A_ENTRY: rdata_o = entry_q;
      A_INIT:  rdata_o = DATA_W'(init_q);
      A_CUR:   rdata_o = DATA_W'(cur_i);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lvec_timer_cnt.sv
module lvec_timer_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cur_q, cur_d;
  logic             step;

  assign step     = tick_i && !load_i && (cur_q != '0);
  assign expire_o = step && (cur_q == ONE);

  always_comb begin
    cur_d = cur_q;
    if (load_i)          cur_d = load_val_i;
    else if (expire_o)   cur_d = periodic_i ? init_i : '0;
    else if (step)       cur_d = cur_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= cur_d;
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/lvec_timer_req.sv
module lvec_timer_req
  import lvec_timer_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   expire_i,
  input  logic   mask_i,
  input  req_t   fields_i,
  output logic   irq_o,
  output req_t   fields_o
);
  logic irq_q;
  req_t fld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fld_q <= '0;
    end else begin
      irq_q <= expire_i && !mask_i;
      if (expire_i) fld_q <= fields_i;
    end
  end

  assign irq_o    = irq_q;
  assign fields_o = fld_q;
endmodule

// File: rtl/lvec_timer.sv
module lvec_timer
  import lvec_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        tick_i,
  output logic        irq_o,
  output logic [7:0]  irq_vector_o,
  output logic [2:0]  irq_mode_o,
  output logic        irq_level_o
);
  entry_t           entry;
  logic [CNT_W-1:0] init_cnt;
  logic [CNT_W-1:0] cur_cnt;
  logic             init_load;
  logic             expire;
  req_t             req_in, req_out;

  lvec_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cur_i   (cur_cnt),
    .entry_o (entry),
    .init_o  (init_cnt),
    .load_o  (init_load),
    .rdata_o (rdata_o)
  );

  lvec_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (init_load),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .init_i     (init_cnt),
    .tick_i     (tick_i),
    .periodic_i (entry.periodic),
    .cur_o      (cur_cnt),
    .expire_o   (expire)
  );

  assign req_in = '{vec: entry.vec, mode: entry.mode, level: entry.level};

  lvec_timer_req u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .mask_i   (entry.mask),
    .fields_i (req_in),
    .irq_o    (irq_o),
    .fields_o (req_out)
  );

  assign irq_vector_o = req_out.vec;
  assign irq_mode_o   = req_out.mode;
  assign irq_level_o  = req_out.level;
endmodule

// File: rtl/lvec_timer_chk.sv
module lvec_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             irq_o,
  input logic [7:0]       irq_vector_o,
  input logic [2:0]       irq_mode_o,
  input logic             irq_level_o,
  input logic [31:0]      entry_i,
  input logic [CNT_W-1:0] init_i,
  input logic [CNT_W-1:0] cur_i,
  input logic             load_i
);
  assert_irq_after_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));

  assert_mask_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(entry_i[16]));

  assert_fields_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_vector_o == $past(entry_i[7:0]) && irq_mode_o == $past(entry_i[10:8])
               && irq_level_o == $past(entry_i[15])));

  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cur_i > CNT_W'(1)) |=> cur_i == $past(cur_i) - CNT_W'(1));

  assert_hold_no_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cur_i));

  assert_zero_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_i == '0 && !load_i) |=> cur_i == '0);

  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cur_i == CNT_W'(1) && entry_i[17]) |=> cur_i == $past(init_i));

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cur_i == init_i);

  assert_ro_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_i[31:18] == '0) && (entry_i[14] == 1'b0) && (entry_i[12:11] == 2'b00));
endmodule

bind lvec_timer lvec_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .irq_o        (irq_o),
  .irq_vector_o (irq_vector_o),
  .irq_mode_o   (irq_mode_o),
  .irq_level_o  (irq_level_o),
  .entry_i      (entry),
  .init_i       (init_cnt),
  .cur_i        (cur_cnt),
  .load_i       (init_load)
);

// File: tb/lvec_timer_tb.sv
`timescale 1ns/1ps
module lvec_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        irq;
  logic [7:0]  irq_vec;
  logic [2:0]  irq_mode;
  logic        irq_lvl;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  logic [7:0] last_vec;
  logic [2:0] last_mode;
  logic       last_lvl;

  always #5 clk = ~clk;

  lvec_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .irq_o(irq), .irq_vector_o(irq_vec),
    .irq_mode_o(irq_mode), .irq_level_o(irq_lvl)
  );

  always @(negedge clk) begin
    if (irq) begin
      irq_cnt  <= irq_cnt + 1;
      last_vec  <= irq_vec;
      last_mode <= irq_mode;
      last_lvl  <= irq_lvl;
    end
  end

  // table: entry, initial count, ticks, expected pulses, expected final count
  localparam int NV = 6;
  localparam logic [31:0] T_ENTRY [NV] = '{32'h0000_0241, 32'h0002_8122, 32'h0001_0033,
                                           32'h0003_0044, 32'h0002_0755, 32'h0000_0066};
  localparam logic [31:0] T_INIT  [NV] = '{32'd5, 32'd3, 32'd4, 32'd2, 32'd1, 32'd0};
  localparam int          T_TICKS [NV] = '{10, 10, 6, 5, 4, 5};
  localparam int          T_IRQS  [NV] = '{1, 3, 0, 0, 4, 0};
  localparam logic [31:0] T_CUR   [NV] = '{32'd0, 32'd2, 32'd0, 32'd1, 32'd1, 32'd0};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic run(input int n);
    irq_cnt = 0;
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(2'd0, d); chk("R1 entry", d, 32'h0001_0000);
    rst_n = 1'b1;
    rd(2'd1, d); chk("R1 init", d, 32'd0);
    rd(2'd2, d); chk("R1 cur", d, 32'd0);

    // table walk: R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, T_ENTRY[i]);
      wr(2'd1, T_INIT[i]);
      run(T_TICKS[i]);
      chk($sformatf("R7/R8/R9 pulses v%0d", i), irq_cnt, T_IRQS[i]);
      rd(2'd2, d); chk($sformatf("R8/R9 count v%0d", i), d, T_CUR[i]);
      if (T_IRQS[i] > 0) begin
        chk($sformatf("R6 vector v%0d", i), {24'd0, last_vec}, {24'd0, T_ENTRY[i][7:0]});
        chk($sformatf("R6 mode v%0d", i), {29'd0, last_mode}, {29'd0, T_ENTRY[i][10:8]});
        chk($sformatf("R6 level v%0d", i), {31'd0, last_lvl}, {31'd0, T_ENTRY[i][15]});
      end
    end

    // R2 masking of read-only and reserved bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R2 entry mask", d, 32'h0003_A7FF);

    // R10 current count not writable, address 3 reads 0
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'd7);
    wr(2'd2, 32'h0000_1234);
    rd(2'd2, d); chk("R10 cur write ignored", d, 32'd7);
    rd(2'd3, d); chk("R10 addr3", d, 32'd0);
    rd(2'd1, d); chk("R3 init readback", d, 32'd7);

    // R4 no tick holds, tick steps
    repeat (4) @(negedge clk);
    rd(2'd2, d); chk("R4 hold", d, 32'd7);
    irq_cnt = 0;
    @(negedge clk); tick = 1'b1;
    repeat (2) @(negedge clk); tick = 1'b0;
    rd(2'd2, d); chk("R4 two ticks", d, 32'd5);

    // R3 rewrite restarts, zero stops
    wr(2'd1, 32'd9);
    rd(2'd2, d); chk("R3 restart", d, 32'd9);
    wr(2'd1, 32'd0);
    run(5);
    chk("R3 zero no pulse", irq_cnt, 32'd0);
    rd(2'd2, d); chk("R3 zero stays", d, 32'd0);

    // R5 exact pulse cycle, entry one-shot vec 0x5A
    wr(2'd0, 32'h0000_005A);
    wr(2'd1, 32'd3);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); chk("R5 after tick1", {31'd0, irq}, 32'd0);
    @(negedge clk); chk("R5 after tick2", {31'd0, irq}, 32'd0);
    @(negedge clk); chk("R5 after tick3", {31'd0, irq}, 32'd1);
    chk("R6 vec 5A", {24'd0, irq_vec}, 32'h5A);
    @(negedge clk); chk("R5 one cycle", {31'd0, irq}, 32'd0);
    tick = 1'b0;

    // R9 one-shot stays quiet after expiry
    run(6);
    chk("R9 no further pulse", irq_cnt, 32'd0);
    rd(2'd2, d); chk("R9 held zero", d, 32'd0);

    // R1 mid-run reset
    wr(2'd0, 32'h0002_0011);
    wr(2'd1, 32'd4);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); tick = 1'b0;
    rd(2'd0, d); chk("R1 reset entry", d, 32'h0001_0000);
    rd(2'd2, d); chk("R1 reset cur", d, 32'd0);
    rd(2'd1, d); chk("R1 reset init", d, 32'd0);
    chk("R1 reset irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule